// File: doc/BRIEF.md
# Serial Receiver Status Flag Unit

This block holds the receive data register and the status flags of a UART-style receiver, between the receive shift register and a CPU bus. When the shifter reports a finished character, the byte is loaded into the data register and the receiver-full flag sets. If the previous character has not been taken yet, the new byte is dropped and the overrun flag sets instead. A separate watcher counts bit times during which the line stays high and raises the idle flag once the line has been quiet long enough. The watcher is armed only by a freshly received character.

Software clears these flags in two steps. A status read records which clearable flags were set at that moment. The next data read then clears exactly those flags. A flag that sets between the two reads therefore survives the data read. The block also drives a receive interrupt request, an error interrupt request, each gated by its enable, and a transmit-complete flag that follows the transmitter's busy indication.

Top module: `rx_status_unit`

## Requirements
- R1: When `char_done` is high with `rx_en` high and `flag_full` low, the next cycle shows `flag_full` = 1 and `data_o` equal to the byte given with the strobe. `flag_full` goes low only on a `rd_data` pulse that comes after a `rd_status` pulse that saw it set. A `rd_data` with no such status read leaves it set.
- R2: `flag_idle` sets on the `bit_tick` that completes IDLE_BITS (default 10) consecutive ticks with `line_level` = 1. A tick with `line_level` = 0 restarts the count.
- R3: After `flag_idle` is cleared, it stays low through any run of high bit times until a new character has been loaded into the data register.
- R4: A `char_done` while `flag_full` is set and not being cleared in that cycle sets `flag_overrun`. The new byte is discarded and `data_o` keeps its old value.
- R5: A `rd_data` clears `flag_overrun` only if `flag_overrun` was already set at the latest `rd_status`. Otherwise it stays set, while `flag_full` seen at that status read is still cleared.
- R6: `irq_rx` is high exactly when (`flag_full` and `full_ie`) or (`flag_idle` and `idle_ie`). The enables act one cycle after they are driven.
- R7: `irq_err` is high exactly when `flag_overrun` is high and `ovr_ie` was high in the previous cycle.
- R8: A cycle with synchronous `rst` high leaves `data_o` = 0, all three clearable flags low, both interrupt requests low and `flag_tc` = 1.
- R9: `flag_tc` is 0 in the cycle after `tx_busy` is high and 1 in the cycle after `tx_busy` is low.
- R10: When a `rd_data` that clears `flag_full` coincides with `char_done`, the new byte is loaded, `flag_full` stays 1 and `flag_overrun` stays 0.
- R11: While `rx_en` is low, `char_done` is ignored and idle detection is disarmed. After `rx_en` returns high, no idle can be reported until a character has been loaded.
- R12: Each `rd_data` consumes the recorded status snapshot. A second `rd_data` without a new `rd_status` clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| char_done | input | 1 | Shifter finished a character (one-cycle strobe) |
| char_data | input | DATA_W | Byte delivered with `char_done` |
| bit_tick | input | 1 | One pulse per received bit time |
| line_level | input | 1 | Receive line level sampled at `bit_tick` |
| rd_status | input | 1 | Bus read of the status register |
| rd_data | input | 1 | Bus read of the data register |
| full_ie | input | 1 | Receiver-full interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| tx_busy | input | 1 | Transmit data, preamble or break queued or in progress |
| data_o | output | DATA_W | Receive data register |
| flag_full | output | 1 | Receiver-full flag |
| flag_idle | output | 1 | Idle-line flag |
| flag_overrun | output | 1 | Overrun flag |
| flag_tc | output | 1 | Transmit-complete flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions check the per-cycle rules on every cycle: a character loaded into an empty register, an overrun that freezes the data, an overrun flag that stays set without a data read, the interrupt gating, idle rising only on a high bit tick, and the transmit-complete and reset behaviour. The remaining behaviour depends on the history of reads, so only the bench scenarios show it. This covers the delayed-clear case where overrun survives a data read, snapshot consumption, the data read that coincides with a new character, exact idle counts with a zero bit in the middle, and re-arming after a clear or a disable.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
  typedef struct packed {
    logic full;
    logic idle;
    logic ovr;
  } flag_snap_t;
endpackage

// File: rtl/rx_flag_core.sv
module rx_flag_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ovr_q,
  output logic              full_nxt,
  output logic              ovr_nxt,
  output logic              load
);
  logic ovr_set;

  // A character lands when the register is empty or is being emptied now
  assign load    = char_done & rx_en & (~full_q | clr_full);
  assign ovr_set = char_done & rx_en & full_q & ~clr_full;

  always_comb begin
    full_nxt = full_q;
    if (clr_full) full_nxt = 1'b0;
    if (load)     full_nxt = 1'b1;
    ovr_nxt = ovr_q;
    if (clr_ovr)  ovr_nxt = 1'b0;
    if (ovr_set)  ovr_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (load) data_q <= char_data;
      full_q <= full_nxt;
      ovr_q  <= ovr_nxt;
    end
  end
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic bit_tick,
  input  logic line_level,
  input  logic load,
  input  logic clr_idle,
  output logic idle_q,
  output logic idle_nxt
);
  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             counting;
  logic             hit;

  assign counting = rx_en & armed & ~idle_q;
  assign hit      = counting & bit_tick & line_level & (cnt == LAST);

  always_comb begin
    idle_nxt = idle_q;
    if (clr_idle) idle_nxt = 1'b0;
    if (hit)      idle_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else begin
      idle_q <= idle_nxt;
      if (!rx_en)               armed <= 1'b0;
      else if (load)            armed <= 1'b1;
      else if (hit || clr_idle) armed <= 1'b0;
      if (!counting || hit)     cnt <= '0;
      else if (bit_tick)        cnt <= line_level ? cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit #(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              bit_tick,
  input  logic              line_level,
  input  logic              rd_status,
  input  logic              rd_data,
  input  logic              full_ie,
  input  logic              idle_ie,
  input  logic              ovr_ie,
  input  logic              tx_busy,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_full,
  output logic              flag_idle,
  output logic              flag_overrun,
  output logic              flag_tc,
  output logic              irq_rx,
  output logic              irq_err
);
  import rx_flag_pkg::*;

  flag_snap_t snap;
  logic full_nxt, ovr_nxt, idle_nxt, load;
  logic clr_full, clr_idle, clr_ovr;

  assign clr_full = rd_data & snap.full;
  assign clr_idle = rd_data & snap.idle;
  assign clr_ovr  = rd_data & snap.ovr;

  rx_flag_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .rx_en(rx_en), .char_done(char_done),
    .char_data(char_data), .clr_full(clr_full), .clr_ovr(clr_ovr),
    .data_q(data_o), .full_q(flag_full), .ovr_q(flag_overrun),
    .full_nxt(full_nxt), .ovr_nxt(ovr_nxt), .load(load)
  );

  rx_idle_watch #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_tick(bit_tick),
    .line_level(line_level), .load(load), .clr_idle(clr_idle),
    .idle_q(flag_idle), .idle_nxt(idle_nxt)
  );

  // Status snapshot: recorded by a status read, consumed by a data read
  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (rd_status) begin
      snap.full <= flag_full;
      snap.idle <= flag_idle;
      snap.ovr  <= flag_overrun;
    end else if (rd_data) begin
      snap <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_tc <= 1'b1;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      flag_tc <= ~tx_busy;
      irq_rx  <= (full_nxt & full_ie) | (idle_nxt & idle_ie);
      irq_err <= ovr_nxt & ovr_ie;
    end
  end
endmodule

// File: rtl/rx_status_unit_chk.sv
module rx_status_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              char_done,
  input logic [DATA_W-1:0] char_data,
  input logic              bit_tick,
  input logic              line_level,
  input logic              rd_data,
  input logic              ovr_ie,
  input logic              tx_busy,
  input logic [DATA_W-1:0] data_o,
  input logic              flag_full,
  input logic              flag_idle,
  input logic              flag_overrun,
  input logic              flag_tc,
  input logic              irq_err
);
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (char_done && rx_en && !flag_full) |=> (flag_full && data_o == $past(char_data))); // R1
  AST_IDLE_ON_HIGH_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_idle) |-> $past(bit_tick && line_level && rx_en)); // R2
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (flag_full && char_done && rx_en && !rd_data) |=> (flag_overrun && $stable(data_o))); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_overrun && !rd_data) |=> flag_overrun); // R5
  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_err == (flag_overrun && $past(ovr_ie))); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (flag_tc && !flag_full && !flag_idle && !flag_overrun)); // R8
  AST_TC_DROPS: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !flag_tc); // R9
  AST_DISABLED_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rd_data) |=> ($stable(data_o) && $stable(flag_full))); // R11
endmodule

bind rx_status_unit rx_status_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .char_done(char_done),
  .char_data(char_data), .bit_tick(bit_tick), .line_level(line_level),
  .rd_data(rd_data), .ovr_ie(ovr_ie), .tx_busy(tx_busy), .data_o(data_o),
  .flag_full(flag_full), .flag_idle(flag_idle), .flag_overrun(flag_overrun),
  .flag_tc(flag_tc), .irq_err(irq_err)
);

// File: tb/rx_status_unit_bench.sv
module rx_status_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int IDLE_BITS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, char_done = 1'b0, bit_tick = 1'b0, line_level = 1'b1;
  logic rd_status = 1'b0, rd_data = 1'b0;
  logic full_ie = 1'b1, idle_ie = 1'b0, ovr_ie = 1'b1, tx_busy = 1'b0;
  logic [DATA_W-1:0] char_data = '0;
  logic [DATA_W-1:0] data_o;
  logic flag_full, flag_idle, flag_overrun, flag_tc, irq_rx, irq_err;

  typedef struct {
    string             tag;
    logic [DATA_W+5:0] vec;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_unit #(.DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS)) u_rx_status_unit (
    .clk(clk), .rst(rst), .rx_en(rx_en), .char_done(char_done),
    .char_data(char_data), .bit_tick(bit_tick), .line_level(line_level),
    .rd_status(rd_status), .rd_data(rd_data), .full_ie(full_ie),
    .idle_ie(idle_ie), .ovr_ie(ovr_ie), .tx_busy(tx_busy), .data_o(data_o),
    .flag_full(flag_full), .flag_idle(flag_idle), .flag_overrun(flag_overrun),
    .flag_tc(flag_tc), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // Monitor: compares every queued expectation away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [DATA_W+5:0] act;
      e   = exp_q.pop_front();
      act = {data_o, flag_full, flag_idle, flag_overrun, flag_tc, irq_rx, irq_err};
      n_vec++;
      if (act !== e.vec) begin
        n_bad++;
        $display("FAIL %s: got data/full/idle/ovr/tc/irx/ierr=%h/%b act, expected %h/%b",
                 e.tag, act[DATA_W+5:6], act[5:0], e.vec[DATA_W+5:6], e.vec[5:0]);
      end
    end
  end

  task automatic expect_st(input string tag, input logic [DATA_W-1:0] d,
                           input logic f, input logic i, input logic o,
                           input logic tc, input logic irx, input logic ierr);
    exp_t e;
    e.tag = tag;
    e.vec = {d, f, i, o, tc, irx, ierr};
    exp_q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    char_done = 1'b0; bit_tick = 1'b0; rd_status = 1'b0; rd_data = 1'b0;
  endtask

  task automatic send(input logic [DATA_W-1:0] b);
    char_done = 1'b1; char_data = b; step();
  endtask

  task automatic sread();
    rd_status = 1'b1; step();
  endtask

  task automatic dread();
    rd_data = 1'b1; step();
  endtask

  task automatic ticks(input int n, input logic lvl);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1'b1; line_level = lvl; step();
    end
    line_level = 1'b1;
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    expect_st("R8 reset state", 8'h00, 0, 0, 0, 1, 0, 0);
    rx_en = 1'b1; step();

    send(8'hA5);
    expect_st("R1 R6 load sets full and irq_rx", 8'hA5, 1, 0, 0, 1, 1, 0);
    dread();
    expect_st("R1 data read without status read keeps full", 8'hA5, 1, 0, 0, 1, 1, 0);
    sread(); dread();
    expect_st("R1 status then data read clears full", 8'hA5, 0, 0, 0, 1, 0, 0);

    send(8'h11); send(8'h22);
    expect_st("R4 R7 overrun keeps old byte", 8'h11, 1, 0, 1, 1, 1, 1);
    sread(); dread();
    expect_st("R5 overrun seen at status read clears", 8'h11, 0, 0, 0, 1, 0, 0);

    send(8'h33); sread(); send(8'h44);
    expect_st("R4 overrun after status read", 8'h33, 1, 0, 1, 1, 1, 1);
    dread();
    expect_st("R5 late overrun survives data read", 8'h33, 0, 0, 1, 1, 0, 1);
    sread(); dread();
    expect_st("R5 second sequence clears overrun", 8'h33, 0, 0, 0, 1, 0, 0);

    send(8'h55); sread(); dread(); send(8'h66); dread();
    expect_st("R12 snapshot consumed by earlier data read", 8'h66, 1, 0, 0, 1, 1, 0);
    sread(); rd_data = 1'b1; send(8'h77);
    expect_st("R10 clearing read with new byte loads it", 8'h77, 1, 0, 0, 1, 1, 0);
    sread(); dread();
    expect_st("R1 clear after same-cycle load", 8'h77, 0, 0, 0, 1, 0, 0);

    idle_ie = 1'b1; step();
    ticks(IDLE_BITS - 1, 1'b1); ticks(1, 1'b0); ticks(IDLE_BITS - 1, 1'b1);
    expect_st("R2 zero bit restarts idle count", 8'h77, 0, 0, 0, 1, 0, 0);
    ticks(1, 1'b1);
    expect_st("R2 R6 idle after full high run", 8'h77, 0, 1, 0, 1, 1, 0);
    sread(); dread();
    expect_st("R3 idle cleared", 8'h77, 0, 0, 0, 1, 0, 0);
    ticks(IDLE_BITS + 2, 1'b1);
    expect_st("R3 no idle before new character", 8'h77, 0, 0, 0, 1, 0, 0);
    send(8'h88); sread(); dread();
    ticks(IDLE_BITS, 1'b1);
    expect_st("R3 idle rearmed by character", 8'h88, 0, 1, 0, 1, 1, 0);
    sread(); dread();

    send(8'h99); sread(); dread();
    rx_en = 1'b0; step();
    send(8'hAA);
    expect_st("R11 char ignored while disabled", 8'h99, 0, 0, 0, 1, 0, 0);
    rx_en = 1'b1; step();
    ticks(IDLE_BITS + 2, 1'b1);
    expect_st("R11 idle disarmed by disable", 8'h99, 0, 0, 0, 1, 0, 0);

    tx_busy = 1'b1; step();
    expect_st("R9 tc low while busy", 8'h99, 0, 0, 0, 0, 0, 0);
    tx_busy = 1'b0; step();
    expect_st("R9 tc high when idle", 8'h99, 0, 0, 0, 1, 0, 0);

    send(8'hBB);
    rst = 1'b1; step(); rst = 1'b0;
    expect_st("R8 reset clears loaded state", 8'h00, 0, 0, 0, 1, 0, 0);
    step(); step();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule